// File: doc/BRIEF.md
# Work-RAM and ROM Strobe Decoder with Refresh Stretch

This block turns the raw signals of a 68000-style bus cycle into the active-low strobes that the memory around the processor needs. Each strobe is a registered output. The block watches the address strobe, the two data strobes, the read/write line and word address bits 23:1, and produces these strobes:

- upper and lower byte-lane write enables;
- a read enable for work RAM;
- a read strobe for ROM and the peripheral space below the work-RAM window;
- a select for work RAM.

When a video DMA engine owns the bus, a mode input widens the address windows. Reads then qualify across the whole 16 MB space, and the RAM select covers the upper half of the space.

Pseudo-static work RAM needs periodic refresh. The block counts completed RAM-select cycles. After a set number of them, it marks the next RAM-select cycle as a refresh cycle. When that cycle's address strobe rises, the RAM select stays low for a set number of extra clocks, and the RAM read enable gives one two-clock pulse in the middle of that hold. A refresh that falls due while the bus is elsewhere waits, as a single pending flag, for the next RAM-select cycle.

Top module: `mem_strobe_gen`

## Requirements
- R1: `uwr_n` is low in a clock only if, in the clock before, `as_n`, `uds_n` and `rw` were all low. `lwr_n` follows the same rule with `lds_n` in place of `uds_n`.
- R2: With `dma_active` low, `oe0_n` goes low one clock after a read (`rw` = 1, `as_n` = 0) whose byte address lies in E00000–FFFFFF. In that case `addr[23:21]` = 3'b111.
- R3: With `dma_active` low, `cas0_n` goes low one clock after a read whose address lies in 000000–DFFFFF. This range includes the C00000–DFFFFF peripheral window. `cas0_n` stays high for writes and for addresses in E00000–FFFFFF.
- R4: With `dma_active` low, `ras0_n` goes low one clock after any cycle with `as_n` low whose address lies in E00000–FFFFFF, whether it is a read or a write.
- R5: With `dma_active` high, `oe0_n` and `cas0_n` go low for a read at any address. `ras0_n` goes low for any access with `addr[23]` = 1, that is, 800000–FFFFFF.
- R6: The block counts completed RAM-select cycles from reset, and the refresh cycle itself is one of them. After every REFRESH_PERIOD completions, the next RAM-select cycle is a refresh cycle. With REFRESH_PERIOD = 6, the 7th, 13th and 19th cycles after reset are refresh cycles.
- R7: In a refresh cycle, `ras0_n` stays low for STRETCH_CLKS clocks after the clock in which it would otherwise rise. The clocks of this hold are numbered from 0. `oe0_n` is low in hold clocks (STRETCH_CLKS-2)/2 and (STRETCH_CLKS-2)/2+1, and high in the others. With STRETCH_CLKS = 4, the pattern is high, low, low, high.
- R8: A due refresh survives any number of clocks and cycles that do not select RAM. It is spent on the next RAM-select cycle only, so the RAM-select cycle after that one has no hold.
- R9: Apart from a refresh hold, every strobe is high in the clock after the one in which `as_n` is sampled high.
- R10: While `rst_n` is low, all five strobes are high, whatever the bus inputs are. Reset also clears the cycle count and any pending refresh, so after reset the (REFRESH_PERIOD+1)th RAM-select cycle is the first refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W (23) | Word address, bits 23:1 |
| dma_active | input | 1 | 1 while the video DMA engine owns the bus |
| uwr_n | output | 1 | Upper byte-lane write strobe |
| lwr_n | output | 1 | Lower byte-lane write strobe |
| oe0_n | output | 1 | Work-RAM read enable |
| cas0_n | output | 1 | ROM and lower-space read strobe |
| ras0_n | output | 1 | Work-RAM select |

## Verification
The assertions assume two things about the inputs. First, the bus inputs are driven to defined levels from time zero. Second, `as_n` stays high for at least STRETCH_CLKS+1 clocks after a cycle ends, so a refresh hold never overlaps the next bus cycle. The stimulus meets both conditions. It drives every input at the falling clock edge. It holds each address-strobe phase for two clocks and then idles for the full hold window plus one clock. Under these conditions, the hold-length counter in the checker never sees a low RAM select that belongs to a new cycle.

// File: rtl/mstb_pkg.sv
package mstb_pkg;

    // Registered strobe set, all active low.
    typedef struct packed {
        logic uwr_n;
        logic lwr_n;
        logic oe0_n;
        logic cas0_n;
        logic ras0_n;
    } strobe_t;

    // Window hits for the current address, active high.
    typedef struct packed {
        logic oe_hit;
        logic cas_hit;
        logic ras_hit;
    } window_t;

    localparam strobe_t STROBES_IDLE = '{default: 1'b1};

endpackage

// File: rtl/mstb_window_dec.sv
module mstb_window_dec
    import mstb_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int WRAM_BITS = 3
) (
    input  logic [ADDR_W:1] addr,
    input  logic            dma_active,
    output window_t         win
);

    localparam logic [WRAM_BITS-1:0] WRAM_TAG = '1;

    logic in_wram;
    logic upper_half;

    always_comb begin
        in_wram    = (addr[ADDR_W -: WRAM_BITS] == WRAM_TAG);
        upper_half = addr[ADDR_W];
        if (dma_active) begin
            win.oe_hit  = 1'b1;
            win.cas_hit = 1'b1;
            win.ras_hit = upper_half;
        end else begin
            win.oe_hit  = in_wram;
            win.cas_hit = ~in_wram;
            win.ras_hit = in_wram;
        end
    end

endmodule

// File: rtl/mstb_refresh.sv
module mstb_refresh #(
    parameter int REFRESH_PERIOD = 64,
    parameter int STRETCH_CLKS   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_req,
    output logic hold,
    output logic pulse
);

    localparam int CW  = $clog2(REFRESH_PERIOD + 1);
    localparam int SW  = $clog2(STRETCH_CLKS + 1);
    localparam int MID = (STRETCH_CLKS - 2) / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
        logic          armed;
        logic          str;
        logic [SW-1:0] sidx;
        logic          req;
    } rf_state_t;

    rf_state_t st_q, st_d;
    logic [SW-1:0] idx;
    logic start_evt, end_evt;

    always_comb begin
        st_d      = st_q;
        st_d.req  = ras_req;
        start_evt = ras_req & ~st_q.req;
        end_evt   = st_q.req & ~ras_req;
        hold      = 1'b0;
        idx       = '0;

        if (end_evt) begin
            if (st_q.cnt == CW'(REFRESH_PERIOD - 1)) begin
                st_d.cnt  = '0;
                st_d.pend = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (start_evt && st_q.pend) begin
            st_d.armed = 1'b1;
            st_d.pend  = 1'b0;
        end

        if (end_evt && st_q.armed) begin
            st_d.armed = 1'b0;
            hold       = 1'b1;
            if (STRETCH_CLKS > 1) begin
                st_d.str  = 1'b1;
                st_d.sidx = SW'(1);
            end
        end

        if (st_q.str) begin
            hold      = 1'b1;
            idx       = st_q.sidx;
            st_d.sidx = st_q.sidx + 1'b1;
            if (st_q.sidx == SW'(STRETCH_CLKS - 1)) begin
                st_d.str = 1'b0;
            end
        end

        pulse = hold && ((idx == SW'(MID)) || (idx == SW'(MID + 1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mem_strobe_gen.sv
module mem_strobe_gen
    import mstb_pkg::*;
#(
    parameter int ADDR_W         = 23,
    parameter int REFRESH_PERIOD = 64,
    parameter int STRETCH_CLKS   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            as_n,
    input  logic            uds_n,
    input  logic            lds_n,
    input  logic            rw,
    input  logic [ADDR_W:1] addr,
    input  logic            dma_active,
    output logic            uwr_n,
    output logic            lwr_n,
    output logic            oe0_n,
    output logic            cas0_n,
    output logic            ras0_n
);

    window_t win;
    strobe_t strb_d, strb_q;
    logic    ras_req;
    logic    rf_hold;
    logic    rf_pulse;
    logic    wr_cyc;
    logic    rd_cyc;

    mstb_window_dec #(
        .ADDR_W    (ADDR_W),
        .WRAM_BITS (3)
    ) u_dec (
        .addr       (addr),
        .dma_active (dma_active),
        .win        (win)
    );

    assign ras_req = ~as_n & win.ras_hit;

    mstb_refresh #(
        .REFRESH_PERIOD (REFRESH_PERIOD),
        .STRETCH_CLKS   (STRETCH_CLKS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_req (ras_req),
        .hold    (rf_hold),
        .pulse   (rf_pulse)
    );

    always_comb begin
        wr_cyc        = ~as_n & ~rw;
        rd_cyc        = ~as_n & rw;
        strb_d.uwr_n  = ~(wr_cyc & ~uds_n);
        strb_d.lwr_n  = ~(wr_cyc & ~lds_n);
        strb_d.cas0_n = ~(rd_cyc & win.cas_hit);
        strb_d.oe0_n  = ~((rd_cyc & win.oe_hit) | rf_pulse);
        strb_d.ras0_n = ~(ras_req | rf_hold);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= STROBES_IDLE;
        end else begin
            strb_q <= strb_d;
        end
    end

    assign uwr_n  = strb_q.uwr_n;
    assign lwr_n  = strb_q.lwr_n;
    assign oe0_n  = strb_q.oe0_n;
    assign cas0_n = strb_q.cas0_n;
    assign ras0_n = strb_q.ras0_n;

endmodule

// File: rtl/mstb_checker.sv
module mstb_checker #(
    parameter int ADDR_W       = 23,
    parameter int STRETCH_CLKS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            as_n,
    input logic            uds_n,
    input logic            lds_n,
    input logic            rw,
    input logic [ADDR_W:1] addr,
    input logic            dma_active,
    input logic            uwr_n,
    input logic            lwr_n,
    input logic            oe0_n,
    input logic            cas0_n,
    input logic            ras0_n
);

    logic        as_q;
    int unsigned hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q     <= 1'b1;
            hold_cnt <= 0;
        end else begin
            as_q     <= as_n;
            hold_cnt <= (!ras0_n && as_q) ? hold_cnt + 1 : 0;
        end
    end

    AST_UWR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !uwr_n |-> $past(!as_n && !uds_n && !rw)); // R1
    AST_LWR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !lwr_n |-> $past(!as_n && !lds_n && !rw)); // R1
    AST_CAS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cas0_n |-> $past(!as_n && rw && (dma_active || addr[ADDR_W -: 3] != 3'b111))); // R3
    AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe0_n |-> ($past(!as_n && rw) || !ras0_n)); // R2
    AST_RELEASE_ON_AS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(as_n) |-> (uwr_n && lwr_n && cas0_n)); // R9
    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= STRETCH_CLKS); // R7

endmodule

bind mem_strobe_gen mstb_checker #(
    .ADDR_W       (ADDR_W),
    .STRETCH_CLKS (STRETCH_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .as_n       (as_n),
    .uds_n      (uds_n),
    .lds_n      (lds_n),
    .rw         (rw),
    .addr       (addr),
    .dma_active (dma_active),
    .uwr_n      (uwr_n),
    .lwr_n      (lwr_n),
    .oe0_n      (oe0_n),
    .cas0_n     (cas0_n),
    .ras0_n     (ras0_n)
);

// File: tb/sim_mem_strobe_gen.sv
module sim_mem_strobe_gen;

    localparam int PER = 6;
    localparam int STR = 4;
    localparam int MID = (STR - 2) / 2;
    localparam int NV  = 16;

    // {dma, rw, uds_n, lds_n, expected {uwr,lwr,oe0,cas0,ras0}, 3'b0, byte address}
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 5'b11101, 3'd0, 24'h000100},
        {1'b0, 1'b1, 1'b0, 1'b0, 5'b11101, 3'd0, 24'hC00004},
        {1'b0, 1'b1, 1'b0, 1'b0, 5'b11101, 3'd0, 24'hDFFFFE},
        {1'b0, 1'b1, 1'b0, 1'b0, 5'b11010, 3'd0, 24'hE00000},
        {1'b0, 1'b1, 1'b0, 1'b0, 5'b11010, 3'd0, 24'hFFFFFE},
        {1'b0, 1'b0, 1'b0, 1'b0, 5'b00110, 3'd0, 24'hFF0000},
        {1'b0, 1'b0, 1'b0, 1'b1, 5'b01110, 3'd0, 24'hFF0000},
        {1'b0, 1'b0, 1'b1, 1'b0, 5'b10111, 3'd0, 24'h200000},
        {1'b0, 1'b1, 1'b0, 1'b0, 5'b11101, 3'd0, 24'h800000},
        {1'b1, 1'b1, 1'b0, 1'b0, 5'b11001, 3'd0, 24'h000000},
        {1'b1, 1'b1, 1'b0, 1'b0, 5'b11001, 3'd0, 24'h7FFFFE},
        {1'b1, 1'b1, 1'b0, 1'b0, 5'b11000, 3'd0, 24'h800000},
        {1'b1, 1'b1, 1'b0, 1'b0, 5'b11000, 3'd0, 24'hC00000},
        {1'b1, 1'b0, 1'b0, 1'b0, 5'b00110, 3'd0, 24'hE00000},
        {1'b1, 1'b0, 1'b1, 1'b0, 5'b10111, 3'd0, 24'h400000},
        {1'b0, 1'b0, 1'b1, 1'b1, 5'b11110, 3'd0, 24'hE00000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        uds_n = 1'b1;
    logic        lds_n = 1'b1;
    logic        rw = 1'b1;
    logic [23:1] addr = '0;
    logic        dma_active = 1'b0;
    logic        uwr_n, lwr_n, oe0_n, cas0_n, ras0_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mem_strobe_gen #(
        .ADDR_W         (23),
        .REFRESH_PERIOD (PER),
        .STRETCH_CLKS   (STR)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_n       (as_n),
        .uds_n      (uds_n),
        .lds_n      (lds_n),
        .rw         (rw),
        .addr       (addr),
        .dma_active (dma_active),
        .uwr_n      (uwr_n),
        .lwr_n      (lwr_n),
        .oe0_n      (oe0_n),
        .cas0_n     (cas0_n),
        .ras0_n     (ras0_n)
    );

    function automatic logic [4:0] strobes();
        return {uwr_n, lwr_n, oe0_n, cas0_n, ras0_n};
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: strobes %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        as_n  = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Work-RAM write cycle; checks the hold window that follows it.
    task automatic ram_cycle(input bit refresh, input string tag);
        @(negedge clk);
        dma_active = 1'b0;
        addr  = 23'h700000;
        rw    = 1'b0;
        uds_n = 1'b0;
        lds_n = 1'b0;
        as_n  = 1'b0;
        @(negedge clk);
        chk(tag, strobes(), 5'b00110);
        as_n  = 1'b1;
        uds_n = 1'b1;
        lds_n = 1'b1;
        rw    = 1'b1;
        for (int k = 0; k < STR; k++) begin
            @(negedge clk);
            if (refresh)
                chk(tag, strobes(), {2'b11, (k == MID || k == MID + 1) ? 1'b0 : 1'b1, 2'b10});
            else
                chk(tag, strobes(), 5'b11111);
        end
        @(negedge clk);
        chk(tag, strobes(), 5'b11111);
    endtask

    // ROM read cycle that never selects work RAM.
    task automatic rom_cycle(input string tag);
        @(negedge clk);
        dma_active = 1'b0;
        addr  = 23'h000800;
        rw    = 1'b1;
        uds_n = 1'b0;
        lds_n = 1'b0;
        as_n  = 1'b0;
        @(negedge clk);
        chk(tag, strobes(), 5'b11101);
        as_n = 1'b1;
        for (int k = 0; k <= STR; k++) begin
            @(negedge clk);
            chk(tag, strobes(), 5'b11111);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        string tag;
        logic [35:0] v;

        // R10: strobes held high during reset despite an active RAM read
        addr = 23'h700000;
        rw   = 1'b1;
        as_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", strobes(), 5'b11111);
        as_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", strobes(), 5'b11111);

        // Decode table, CPU and DMA windows
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (v[35])            tag = "R5";
            else if (!v[34])      tag = "R1";
            else if (!v[24])      tag = "R2/R4";
            else                  tag = "R3";
            @(negedge clk);
            dma_active = v[35];
            rw    = v[34];
            uds_n = v[33];
            lds_n = v[32];
            addr  = v[23:1];
            as_n  = 1'b0;
            @(negedge clk);
            chk(tag, strobes(), v[31:27]);
            @(negedge clk);
            chk(tag, strobes(), v[31:27]);
            as_n  = 1'b1;
            uds_n = 1'b1;
            lds_n = 1'b1;
            @(negedge clk);
            // R9: write and lower-space strobes release at once
            chk("R9", {strobes()[4:3], strobes()[1]}, 3'b111);
            repeat (STR + 1) @(negedge clk);
        end
        dma_active = 1'b0;

        // R6 and R7: cadence and hold shape
        do_reset();
        for (int i = 1; i <= 2 * PER + 1; i++) begin
            ram_cycle(i == PER + 1 || i == 2 * PER + 1, "R6/R7");
        end

        // R8: pending refresh waits through non-RAM activity, spent once
        do_reset();
        for (int i = 1; i <= PER; i++) ram_cycle(1'b0, "R8");
        for (int i = 0; i < 3; i++) rom_cycle("R8");
        repeat (10) @(negedge clk);
        chk("R8", strobes(), 5'b11111);
        ram_cycle(1'b1, "R8");
        ram_cycle(1'b0, "R8");

        // R10: reset drops a pending refresh and clears the count
        do_reset();
        for (int i = 1; i <= PER; i++) ram_cycle(1'b0, "R10");
        do_reset();
        for (int i = 1; i <= PER; i++) ram_cycle(1'b0, "R10");
        ram_cycle(1'b1, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule